// File: doc/BRIEF.md
# DDS Register Load Controller

This block is the host-side register file of a direct digital synthesizer. A host builds 32-bit words in one of two assembly registers. The parallel assembly register takes bus beats of 8 or 16 bits, and a command bit selects the width. The serial assembly register takes one bit per accepted beat. A load strobe, qualified by a 4-bit transfer code, then copies one assembly register into one destination. The destinations are a 4-bit command register, two 32-bit frequency words, a 12-bit phase offset and a 20-bit I/Q amplitude word.

The load strobe, the transfer code and the frequency-select input can pass through a four-stage pipeline in the system clock domain. A command bit lets them bypass it, which gives a faster response. All destination registers and the decoded command bits are outputs for the synthesis datapath. Both data inputs use valid/ready. Ready is held high at all times, so the block never applies back-pressure, and a beat is taken on every cycle that valid is high.

Top module: `dds_regfile_ctrl`

## Requirements
- R1: After reset every destination register, the command register, both assembly registers and the frequency-select output are zero.
- R2: While command bit 0 is 0 (8-bit mode), each accepted bus beat shifts the parallel assembly register left by 8 and inserts data bits 7:0 at the bottom. Data bits 15:8 are ignored. Four beats fill the word, with the first beat ending up in the most significant byte.
- R3: While command bit 0 is 1 (16-bit mode), each accepted bus beat shifts the parallel assembly register left by 16 and inserts all 16 data bits. Two beats fill the word.
- R4: Each accepted serial beat shifts the serial assembly register left by 1 and inserts the serial bit, so a word is sent most significant bit first.
- R5: A transfer happens only on a rising edge of the effective load strobe. While load is 0, no transfer code changes any register. Holding load high does not repeat the transfer.
- R6: A transfer with code bit 3 equal to 0 copies parallel assembly bits 3:0 into the command register, whatever code bits 2:0 hold. The serial register never reaches the command register.
- R7: A transfer with code bits 3:2 equal to 10 copies the parallel assembly register into a destination chosen by code bits 1:0. The mapping is 00 frequency word 0, 01 frequency word 1, 10 phase (low 12 bits) and 11 I/Q amplitude (low 20 bits).
- R8: A transfer with code bits 3:2 equal to 11 copies the serial assembly register into the destination chosen by the same bits 1:0 mapping.
- R9: The decoded outputs follow the command register: bit 0 is the bus width, bit 1 is sleep, bit 2 enables amplitude modulation and bit 3 disables the synchronizer.
- R10: With command bit 3 at 0, the frequency-select output follows its input 4 clock edges later. A load rising edge first changes a destination at the 5th clock edge after it is sampled.
- R11: With command bit 3 at 1, the frequency-select output follows its input with no clock delay, and a load rising edge changes a destination at the 1st clock edge.
- R12: Both data-input ready outputs are high out of reset and stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Parallel bus beat valid |
| wr_ready_o | output | 1 | Parallel bus ready (always high) |
| wr_data_i | input | 16 | Parallel bus data |
| ser_valid_i | input | 1 | Serial beat valid |
| ser_ready_o | output | 1 | Serial ready (always high) |
| ser_bit_i | input | 1 | Serial data bit |
| load_i | input | 1 | Transfer strobe |
| tc_i | input | 4 | Transfer code (source and destination) |
| fsel_i | input | 1 | Frequency word select |
| cmd_o | output | 4 | Command register |
| wide_bus_o | output | 1 | 16-bit bus mode |
| sleep_o | output | 1 | Sleep request |
| am_en_o | output | 1 | Amplitude modulation enable |
| sync_off_o | output | 1 | Synchronizer bypassed |
| fsel_o | output | 1 | Effective frequency select |
| freq0_o | output | 32 | Frequency word 0 |
| freq1_o | output | 32 | Frequency word 1 |
| phase_o | output | 12 | Phase offset |
| iqmod_o | output | 20 | I/Q amplitude word |

## Verification
The assertions assume that the transfer code is already valid on the cycle the effective load rises, and that the host does not change the width bit while a parallel word is only partly assembled. The stimulus meets both conditions. It applies the code together with load and holds both steady for several cycles. It finishes each parallel word, then loads the command register and only after that starts a new word. A synchronizer mode change is made only through a complete transfer followed by idle cycles.

// File: rtl/dds_ctl_pkg.sv
package dds_ctl_pkg;
  localparam int unsigned TC_W = 4;

  // command register bit positions (decoded by the datapath)
  localparam int unsigned CMD_WIDE  = 0;
  localparam int unsigned CMD_SLEEP = 1;
  localparam int unsigned CMD_AM    = 2;
  localparam int unsigned CMD_NOSYN = 3;
  localparam int unsigned CMD_W     = 4;

  // transfer code fields
  localparam int unsigned TC_DATA = 3;  // 0: command load
  localparam int unsigned TC_SRC  = 2;  // 1: serial source

  typedef enum logic [1:0] {
    DST_FREQ0 = 2'b00,
    DST_FREQ1 = 2'b01,
    DST_PHASE = 2'b10,
    DST_IQMOD = 2'b11
  } dst_e;

  typedef struct packed {
    logic            fsel;
    logic            load;
    logic [TC_W-1:0] tc;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dds_ctl_sync.sv
module dds_ctl_sync
  import dds_ctl_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_i,
  input  ctl_t ctl_i,
  output ctl_t ctl_o
);
  ctl_t pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '0;
          else        pipe_q[s] <= ctl_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= '0;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign ctl_o = bypass_i ? ctl_i : pipe_q[STAGES-1];
endmodule

// File: rtl/dds_par_asm.sv
module dds_par_asm #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [BUS_W-1:0]  data_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned NARROW_W = BUS_W / 2;

  logic [WORD_W-1:0] word_q;

  assign ready_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (valid_i) begin
      if (wide_i) word_q <= {word_q[WORD_W-BUS_W-1:0], data_i};
      else        word_q <= {word_q[WORD_W-NARROW_W-1:0], data_i[NARROW_W-1:0]};
    end
  end

  assign word_o = word_q;

  a_r2_narrow_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !wide_i) |=> (word_o[WORD_W-1:NARROW_W] == $past(word_o[WORD_W-NARROW_W-1:0]))
                          && (word_o[NARROW_W-1:0] == $past(data_i[NARROW_W-1:0])));

  a_r3_wide_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && wide_i) |=> (word_o[WORD_W-1:BUS_W] == $past(word_o[WORD_W-BUS_W-1:0]))
                         && (word_o[BUS_W-1:0] == $past(data_i)));
endmodule

// File: rtl/dds_ser_asm.sv
module dds_ser_asm #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  assign ready_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (valid_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;

  a_r4_serial_shift: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (word_o[0] == $past(bit_i)) && (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));

  a_r4_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(word_o));
endmodule

// File: rtl/dds_regfile_ctrl.sv
module dds_regfile_ctrl
  import dds_ctl_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned PHASE_W = 12,
  parameter int unsigned IQ_W    = 20,
  parameter int unsigned STAGES  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [BUS_W-1:0]   wr_data_i,
  input  logic               ser_valid_i,
  output logic               ser_ready_o,
  input  logic               ser_bit_i,
  input  logic               load_i,
  input  logic [3:0]         tc_i,
  input  logic               fsel_i,
  output logic [3:0]         cmd_o,
  output logic               wide_bus_o,
  output logic               sleep_o,
  output logic               am_en_o,
  output logic               sync_off_o,
  output logic               fsel_o,
  output logic [WORD_W-1:0]  freq0_o,
  output logic [WORD_W-1:0]  freq1_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [IQ_W-1:0]    iqmod_o
);
  logic [CMD_W-1:0]   cmd_q;
  logic [WORD_W-1:0]  par_word, ser_word, src_word;
  logic [WORD_W-1:0]  freq0_q, freq1_q;
  logic [PHASE_W-1:0] phase_q;
  logic [IQ_W-1:0]    iq_q;
  logic               ld_prev_q, fire;
  ctl_t               ctl_raw, ctl_eff;

  dds_par_asm #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_par (
    .clk(clk), .rst_n(rst_n), .wide_i(cmd_q[CMD_WIDE]), .valid_i(wr_valid_i),
    .ready_o(wr_ready_o), .data_i(wr_data_i), .word_o(par_word)
  );

  dds_ser_asm #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .valid_i(ser_valid_i), .ready_o(ser_ready_o),
    .bit_i(ser_bit_i), .word_o(ser_word)
  );

  assign ctl_raw = '{fsel: fsel_i, load: load_i, tc: tc_i};

  dds_ctl_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bypass_i(cmd_q[CMD_NOSYN]),
    .ctl_i(ctl_raw), .ctl_o(ctl_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_prev_q <= 1'b0;
    else        ld_prev_q <= ctl_eff.load;
  end

  assign fire     = ctl_eff.load && !ld_prev_q;
  assign src_word = ctl_eff.tc[TC_SRC] ? ser_word : par_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      freq0_q <= '0;
      freq1_q <= '0;
      phase_q <= '0;
      iq_q    <= '0;
    end else if (fire) begin
      if (!ctl_eff.tc[TC_DATA]) begin
        cmd_q <= par_word[CMD_W-1:0];
      end else begin
        unique case (dst_e'(ctl_eff.tc[1:0]))
          DST_FREQ0: freq0_q <= src_word;
          DST_FREQ1: freq1_q <= src_word;
          DST_PHASE: phase_q <= src_word[PHASE_W-1:0];
          DST_IQMOD: iq_q    <= src_word[IQ_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign wide_bus_o = cmd_q[CMD_WIDE];
  assign sleep_o    = cmd_q[CMD_SLEEP];
  assign am_en_o    = cmd_q[CMD_AM];
  assign sync_off_o = cmd_q[CMD_NOSYN];
  assign fsel_o     = ctl_eff.fsel;
  assign freq0_o    = freq0_q;
  assign freq1_o    = freq1_q;
  assign phase_o    = phase_q;
  assign iqmod_o    = iq_q;

  a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_eff.load && !ld_prev_q) |=> $stable({cmd_o, freq0_o, freq1_o, phase_o, iqmod_o}));

  a_r6_cmd_from_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl_eff.tc[TC_DATA]) |=> (cmd_o == $past(par_word[CMD_W-1:0])));

  a_r8_serial_to_freq0: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl_eff.tc == 4'b1100) |=> (freq0_o == $past(ser_word)));

  a_r7_parallel_to_freq1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl_eff.tc == 4'b1001) |=> (freq1_o == $past(par_word)));
endmodule

// File: tb/test_dds_regfile_ctrl.sv
module test_dds_regfile_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, ser_valid = 1'b0, ser_bit = 1'b0;
  logic [15:0] wr_data = '0;
  logic        load = 1'b0, fsel = 1'b0;
  logic [3:0]  tc = '0;
  logic        wr_ready, ser_ready, wide_bus, sleep, am_en, sync_off, fsel_out;
  logic [3:0]  cmd;
  logic [31:0] freq0, freq1;
  logic [11:0] phase;
  logic [19:0] iqmod;

  int checks = 0, errors = 0;
  logic [31:0] e_par = '0, e_ser = '0, e_f0 = '0, e_f1 = '0;
  logic [11:0] e_ph = '0;
  logic [19:0] e_iq = '0;
  logic [3:0]  e_cmd = '0;

  always #4 clk = ~clk;

  dds_regfile_ctrl i_dds_regfile_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_data_i(wr_data), .ser_valid_i(ser_valid), .ser_ready_o(ser_ready),
    .ser_bit_i(ser_bit), .load_i(load), .tc_i(tc), .fsel_i(fsel), .cmd_o(cmd),
    .wide_bus_o(wide_bus), .sleep_o(sleep), .am_en_o(am_en), .sync_off_o(sync_off),
    .fsel_o(fsel_out), .freq0_o(freq0), .freq1_o(freq1), .phase_o(phase), .iqmod_o(iqmod)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "freq0", freq0, e_f0);
    chk(req, "freq1", freq1, e_f1);
    chk(req, "phase", {20'h0, phase}, {20'h0, e_ph});
    chk(req, "iqmod", {12'h0, iqmod}, {12'h0, e_iq});
    chk(req, "cmd", {28'h0, cmd}, {28'h0, e_cmd});
    chk("R9", "decode", {28'h0, sync_off, am_en, sleep, wide_bus}, {28'h0, e_cmd});
  endtask

  task automatic par_write(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    e_par = e_cmd[0] ? {e_par[15:0], d} : {e_par[23:0], d[7:0]};
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_par8(input logic [31:0] w);
    for (int b = 3; b >= 0; b--) par_write({8'hA5 ^ 8'(b), w[b*8 +: 8]});
  endtask

  task automatic load_par16(input logic [31:0] w);
    par_write(w[31:16]);
    par_write(w[15:0]);
  endtask

  task automatic ser_shift(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      ser_valid = 1'b1;
      ser_bit   = w[i];
      e_ser = {e_ser[30:0], w[i]};
    end
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  task automatic model_xfer(input logic [3:0] code);
    logic [31:0] s;
    s = code[2] ? e_ser : e_par;
    if (!code[3]) e_cmd = e_par[3:0];
    else case (code[1:0])
      2'b00: e_f0 = s;
      2'b01: e_f1 = s;
      2'b10: e_ph = s[11:0];
      default: e_iq = s[19:0];
    endcase
  endtask

  task automatic xfer(input logic [3:0] code);
    @(negedge clk);
    tc = code;
    load = 1'b1;
    repeat (6) @(negedge clk);
    load = 1'b0;
    model_xfer(code);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state, R12 ready
    chk_all("R1");
    chk("R1", "fsel_o", {31'h0, fsel_out}, 32'h0);
    chk("R12", "ready", {30'h0, wr_ready, ser_ready}, 32'h3);

    // R2 / R7: 8-bit parallel words to each destination
    for (int d = 0; d < 4; d++) begin
      load_par8(32'h9E3779B9 * (d + 1));
      xfer({2'b10, 2'(d)});
      chk_all("R7");
      chk("R2", "assembled", (d == 0) ? freq0 : (d == 1) ? freq1 : (d == 2) ? {20'h0, phase} : {12'h0, iqmod},
          (d == 0) ? 32'h9E3779B9 : (d == 1) ? 32'h9E3779B9 * 2 : (d == 2) ? ((32'h9E3779B9 * 3) & 32'hFFF)
                                                                           : ((32'h9E3779B9 * 4) & 32'hFFFFF));
    end

    // R4 / R8: serial words to each destination
    for (int d = 0; d < 4; d++) begin
      ser_shift(32'h7F4A7C15 * (d + 3));
      xfer({2'b11, 2'(d)});
      chk_all("R8");
    end
    chk("R4", "freq0 serial", freq0, 32'h7F4A7C15 * 3);

    // R5: load low, every code, no transfer
    load_par8(32'hCAFEF00D);
    ser_shift(32'h0BADBEEF);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      tc = 4'(c);
      repeat (7) @(negedge clk);
      chk_all("R5");
    end

    // R5: load held high fires once
    @(negedge clk);
    tc = 4'b1000;
    load = 1'b1;
    model_xfer(4'b1000);
    repeat (6) @(negedge clk);
    load_par8(32'h11223344);
    repeat (6) @(negedge clk);
    chk("R5", "no repeat while high", freq0, 32'hCAFEF00D);
    load = 1'b0;
    repeat (6) @(negedge clk);

    // R6 / R9: command loads with tc3=0 and varied low bits
    for (int k = 0; k < 8; k++) begin
      load_par8({28'h0, 4'(k) & 4'b0110});
      xfer({1'b0, 3'(k)});
      chk_all("R6");
    end
    load_par8(32'h0);
    ser_shift(32'hFFFFFFFF);
    xfer(4'b0100);
    chk_all("R6");

    // R3: 16-bit mode
    load_par8(32'h1);
    xfer(4'b0000);
    load_par16(32'hDEADBEEF);
    xfer(4'b1001);
    chk("R3", "freq1 wide", freq1, 32'hDEADBEEF);
    chk_all("R3");

    // R10: synchronized latency
    load_par16(32'h5A5AC3C3);
    @(negedge clk);
    tc = 4'b1000;
    load = 1'b1;
    fsel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "fsel after 3", {31'h0, fsel_out}, 32'h0);
    @(posedge clk);
    #1;
    chk("R10", "fsel after 4", {31'h0, fsel_out}, 32'h1);
    chk("R10", "freq0 after 4", freq0, e_f0);
    @(posedge clk);
    #1;
    chk("R10", "freq0 after 5", freq0, 32'h5A5AC3C3);
    model_xfer(4'b1000);
    @(negedge clk);
    load = 1'b0;
    repeat (6) @(negedge clk);

    // R11: bypass mode
    load_par16(32'h00000009);
    xfer(4'b0110);
    chk_all("R11");
    @(negedge clk);
    fsel = 1'b0;
    #1;
    chk("R11", "fsel bypass 0", {31'h0, fsel_out}, 32'h0);
    fsel = 1'b1;
    #1;
    chk("R11", "fsel bypass 1", {31'h0, fsel_out}, 32'h1);
    load_par16(32'h00000ABC);
    @(negedge clk);
    tc = 4'b1010;
    load = 1'b1;
    #1;
    chk("R11", "phase before edge", {20'h0, phase}, {20'h0, e_ph});
    @(posedge clk);
    #1;
    chk("R11", "phase after 1", {20'h0, phase}, 32'hABC);
    model_xfer(4'b1010);
    @(negedge clk);
    load = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R11");
    chk("R12", "ready end", {30'h0, wr_ready, ser_ready}, 32'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule